// File: doc/BRIEF.md
# Serial port interrupt aggregator

This block gathers the interrupt events of a synchronous serial port that has a transmit FIFO and a receive FIFO. It has seven sources. Two are FIFO service requests that follow the fill levels at the half-depth point. Five are sticky events: receive overrun, receive idle time-out, end of transmission, and the completion of a transmit or a receive DMA transfer. Each source is reported raw and masked. The masked sources are also ORed into one request line, so software can serve them from one global handler or from separate drivers.

The block also contains the receive idle time-out counter. The counter waits while the receive FIFO is empty. Every push or pop reloads it. Each serial clock tick counts it down while the FIFO holds data. It raises the time-out event when it reaches zero and the data has not moved. End of transmission is taken from the falling edge of the shifter's busy flag, and only when the transmit FIFO is empty at that moment. A small write port loads the enable mask or clears sticky events.

Top module: `ssp_irq_agg`

## Requirements
- R1: Status bit 0 (transmit service) is 1 while `tx_level_i` is at most DEPTH/2, and 0 otherwise. The bit follows the level in the same cycle.
- R2: Status bit 1 (receive service) is 1 while `rx_level_i` is at least DEPTH/2, and 0 otherwise. The bit follows the level in the same cycle.
- R3: A pulse on `rx_ovr_i` sets bit 3. A pulse on `rx_dma_done_i` sets bit 5. A pulse on `tx_dma_done_i` sets bit 6. Each bit reads 1 from the cycle after its pulse and holds there until it is cleared.
- R4: Bit 4 (end of transmission) is set in the cycle after `shift_busy_i` falls while `tx_level_i` is 0. A busy fall while the transmit FIFO holds data leaves bit 4 at 0.
- R5: Bit 2 (receive time-out) works from a counter. A push or pop on `rx_push_i` or `rx_pop_i` reloads the counter to TO_RELOAD, and so does an empty receive FIFO. Each `sclk_tick_i` counts it down while the FIFO is non-empty. Bit 2 is set on the TO_RELOAD-th tick after the last push or pop, and not before that tick. While the FIFO is empty, ticks never set bit 2.
- R6: A write with `wr_en_i`=1 and `wr_sel_i`=1 clears each of bits 2 to 6 whose `wr_data_i` bit is 1. Bits 0 and 1 are not affected by this write. A set event in the same cycle as the clear takes priority over the clear.
- R7: A write with `wr_en_i`=1 and `wr_sel_i`=0 loads the enable mask from `wr_data_i`, where 1 enables a source. `mis_o` equals `raw_o` AND the mask. `irq_o` is the OR of all bits of `mis_o`.
- R8: After reset, the mask and all sticky bits are 0. `mis_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_level_i | input | LVL_W | Entries held in the transmit FIFO |
| rx_level_i | input | LVL_W | Entries held in the receive FIFO |
| rx_push_i | input | 1 | Strobe for a word written into the receive FIFO |
| rx_pop_i | input | 1 | Strobe for a word read from the receive FIFO |
| sclk_tick_i | input | 1 | One strobe per serial clock period |
| shift_busy_i | input | 1 | Shifter is transferring a frame |
| rx_ovr_i | input | 1 | Receive overrun pulse |
| rx_dma_done_i | input | 1 | Receive DMA transfer complete pulse |
| tx_dma_done_i | input | 1 | Transmit DMA transfer complete pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 = mask, 1 = clear |
| wr_data_i | input | 7 | Write data, one bit per source |
| raw_o | output | 7 | Status of each source before masking |
| mis_o | output | 7 | Status of each source after masking |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: DEPTH=8 and TO_RELOAD=32. With DEPTH=8 the half-depth point is level 4. Each service bit can therefore be driven just inside and just outside its threshold: 4 and 5 for transmit, 3 and 4 for receive. With TO_RELOAD=32 the bench can count 31 ticks and then the 32nd, so it sees the tick before the time-out and the tick that sets it. It also checks that a pop reloads the count, and that ticks never set bit 2 while the receive FIFO is empty.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;
  localparam int NSRC     = 7;
  localparam int SRC_TXS  = 0;
  localparam int SRC_RXS  = 1;
  localparam int SRC_RTO  = 2;
  localparam int SRC_OVR  = 3;
  localparam int SRC_EOT  = 4;
  localparam int SRC_RDMA = 5;
  localparam int SRC_TDMA = 6;
  localparam int FIRST_STICKY = SRC_RTO;
  localparam int NSTICKY  = NSRC - FIRST_STICKY;
endpackage

// File: rtl/ssp_irq_fifo_trig.sv
module ssp_irq_fifo_trig #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  output logic             tx_svc_o,
  output logic             rx_svc_o
);
  localparam int HALF = DEPTH / 2;

  assign tx_svc_o = (32'(tx_level_i) <= HALF);
  assign rx_svc_o = (32'(rx_level_i) >= HALF);
endmodule

// File: rtl/ssp_irq_rx_timeout.sv
module ssp_irq_rx_timeout #(
  parameter int TO_RELOAD = 32,
  localparam int CNT_W = $clog2(TO_RELOAD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nonempty_i,
  input  logic push_i,
  input  logic pop_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TO_RELOAD);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             hold;

  // reload on data movement or while empty
  assign hold   = !nonempty_i || push_i || pop_i;
  assign fire_o = !hold && tick_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= RELOAD;
    else if (hold)                     cnt_q <= RELOAD;
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/ssp_irq_sticky.sv
module ssp_irq_sticky #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ssp_irq_agg.sv
module ssp_irq_agg
  import ssp_irq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int TO_RELOAD = 32,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             sclk_tick_i,
  input  logic             shift_busy_i,
  input  logic             rx_ovr_i,
  input  logic             rx_dma_done_i,
  input  logic             tx_dma_done_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [NSRC-1:0]  wr_data_i,
  output logic [NSRC-1:0]  raw_o,
  output logic [NSRC-1:0]  mis_o,
  output logic             irq_o
);
  logic              tx_svc, rx_svc, rto_fire, eot_evt, busy_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   set_vec, clr_vec;
  logic [NSTICKY-1:0] sticky_q;

  ssp_irq_fifo_trig #(.DEPTH(DEPTH)) u_trig (
    .tx_level_i (tx_level_i),
    .rx_level_i (rx_level_i),
    .tx_svc_o   (tx_svc),
    .rx_svc_o   (rx_svc)
  );

  ssp_irq_rx_timeout #(.TO_RELOAD(TO_RELOAD)) u_rto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nonempty_i (rx_level_i != '0),
    .push_i     (rx_push_i),
    .pop_i      (rx_pop_i),
    .tick_i     (sclk_tick_i),
    .fire_o     (rto_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= shift_busy_i;
  end

  assign eot_evt = busy_q && !shift_busy_i && (tx_level_i == '0);

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_RTO]  = rto_fire;
    set_vec[SRC_OVR]  = rx_ovr_i;
    set_vec[SRC_EOT]  = eot_evt;
    set_vec[SRC_RDMA] = rx_dma_done_i;
    set_vec[SRC_TDMA] = tx_dma_done_i;
    clr_vec           = (wr_en_i && wr_sel_i) ? wr_data_i : '0;
  end

  ssp_irq_sticky #(.W(NSTICKY)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec[NSRC-1:FIRST_STICKY]),
    .clr_i  (clr_vec[NSRC-1:FIRST_STICKY]),
    .q_o    (sticky_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mask_q <= '0;
    else if (wr_en_i && !wr_sel_i) mask_q <= wr_data_i;
  end

  assign raw_o = {sticky_q, rx_svc, tx_svc};
  assign mis_o = raw_o & mask_q;
  assign irq_o = |mis_o;
endmodule

// File: rtl/ssp_irq_agg_chk.sv
module ssp_irq_agg_chk #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] tx_level_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic             rx_ovr_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [6:0]       wr_data_i,
  input logic [6:0]       mask_q,
  input logic [6:0]       raw_o,
  input logic             irq_o
);
  AST_TX_SVC_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(tx_level_i) <= DEPTH / 2) |-> raw_o[0]); // R1
  AST_RX_SVC_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rx_level_i) >= DEPTH / 2) |-> raw_o[1]); // R2
  AST_OVR_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovr_i |=> raw_o[3]); // R3
  AST_CLR_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && wr_data_i[3] && !rx_ovr_i) |=> !raw_o[3]); // R6
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (mask_q == $past(wr_data_i))); // R7
  AST_NO_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R8
endmodule

bind ssp_irq_agg ssp_irq_agg_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_level_i (tx_level_i),
  .rx_level_i (rx_level_i),
  .rx_ovr_i   (rx_ovr_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .mask_q     (mask_q),
  .raw_o      (raw_o),
  .irq_o      (irq_o)
);

// File: tb/ssp_irq_agg_tb.sv
module ssp_irq_agg_tb;
  localparam int DEPTH = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic rx_push = 0, rx_pop = 0, tick = 0, busy = 0;
  logic ovr = 0, rdma = 0, tdma = 0, wr_en = 0, wr_sel = 0;
  logic [6:0] wr_data = '0;
  logic [6:0] raw, mis;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ssp_irq_agg #(.DEPTH(DEPTH), .TO_RELOAD(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_level_i(tx_level), .rx_level_i(rx_level),
    .rx_push_i(rx_push), .rx_pop_i(rx_pop), .sclk_tick_i(tick),
    .shift_busy_i(busy), .rx_ovr_i(ovr), .rx_dma_done_i(rdma),
    .tx_dma_done_i(tdma), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .raw_o(raw), .mis_o(mis), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [6:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 0; wr_data = '0;
  endtask

  task automatic t_reset();
    step();
    chk("R8 raw", raw, 7'h01);
    chk("R8 mis", mis, 0);
    chk("R8 irq", irq, 0);
  endtask

  task automatic t_service();
    tx_level = 4; rx_level = 3; #1;
    chk("R1 tx=4", raw[0], 1);
    chk("R2 rx=3", raw[1], 0);
    tx_level = 5; rx_level = 4; #1;
    chk("R1 tx=5", raw[0], 0);
    chk("R2 rx=4", raw[1], 1);
    tx_level = 0; rx_level = 0; step();
  endtask

  task automatic t_mask();
    wr(0, 7'h01);
    chk("R7 mis tx", mis, 7'h01);
    chk("R7 irq on", irq, 1);
    tx_level = 6; #1;
    chk("R7 irq off", irq, 0);
    tx_level = 0;
    wr(0, 7'h00);
  endtask

  task automatic t_sticky();
    ovr = 1; rdma = 1; tdma = 1; step();
    ovr = 0; rdma = 0; tdma = 0;
    chk("R3 set", raw[6:3] & 4'b1101, 4'b1101);
    step(3);
    chk("R3 hold", raw[6:3] & 4'b1101, 4'b1101);
    wr(0, 7'h08);
    chk("R7 ovr mis", mis, 7'h08);
    chk("R7 ovr irq", irq, 1);
    wr(1, 7'h7f);
    chk("R6 clr", raw, 7'h01);
    chk("R6 irq", irq, 0);
    ovr = 1; wr(1, 7'h08); ovr = 0;
    chk("R6 set wins", raw[3], 1);
    wr(1, 7'h08);
    wr(0, 7'h00);
  endtask

  task automatic t_eot();
    busy = 1; tx_level = 2; step();
    busy = 0; step();
    chk("R4 nonempty", raw[4], 0);
    busy = 1; tx_level = 0; step();
    busy = 0; step();
    chk("R4 eot", raw[4], 1);
    wr(1, 7'h10);
    chk("R4 cleared", raw[4], 0);
  endtask

  task automatic t_timeout();
    tick = 1; step(40);
    chk("R5 empty", raw[2], 0);
    tick = 0;
    rx_push = 1; rx_level = 1; step();
    rx_push = 0;
    tick = 1; step(20);
    tick = 0; rx_pop = 1; rx_push = 1; step();
    rx_pop = 0; rx_push = 0;
    tick = 1; step(31);
    tick = 0; step();
    chk("R5 31 ticks", raw[2], 0);
    tick = 1; step();
    tick = 0;
    chk("R5 32nd tick", raw[2], 1);
    rx_level = 0;
    wr(1, 7'h04);
    chk("R5 cleared", raw[2], 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    step(2);
    rst_n = 1;
    t_reset();
    t_service();
    t_mask();
    t_sticky();
    t_eot();
    t_timeout();
    finish_run();
  end
endmodule